// File: doc/BRIEF.md
# Link Interrupt Forwarding Router

This block sits between a device's event sources and a chip-to-chip link. It watches 64 event lines. Lines 0 to 31 carry system interrupt controller events and lines 32 to 63 carry queue-pending signals. For each line, an entry in a control table decides what happens to a new event. The event can be ignored, it can set a bit in a 32-bit local status register, or it can be queued as an interrupt packet for the remote device. Software can also raise any of the 64 events by writing its number to a trigger register.

Packets that arrive from the remote device carry a vector. A vector below 32 selects a control-table entry. That entry either maps the packet into a local status bit or turns it into a one-cycle pulse with a vector toward the chip's interrupt controller. A vector of 32 or above is dropped and counted. Any nonzero status drives a single combined interrupt output.

Software reaches the block through a small register port with combinational read-back. It loads the control table one entry at a time through an index register and a value register.

Top module: `link_irq_router`

## Requirements
- R1: After reset the status register, error count and overflow flag read 0, `irq_out`, `tx_valid` and `soc_irq_valid` are 0, and every control entry reads 0, which means disabled.
- R2: On a rising edge of event line i, when entry i has enable=1 and local=1, status bit `vec` of entry i is set at the next clock edge. Holding the line high does not set the bit again after it has been cleared.
- R3: An event whose entry has enable=0 changes neither the status register nor the packet output.
- R4: An enabled event with local=0 produces a packet on `tx_vec` that carries the entry's `vec`. When several such events fire in the same cycle, their packets leave in ascending event-line order.
- R5: While `tx_ready` is 0, packets wait in a queue and `tx_vec` holds steady. If a remote event fires again while its earlier occurrence is still waiting to enter the queue, the overflow flag (bit 16 at address 5) is set. Writing 1 to that bit clears the flag.
- R6: A received packet with vector v < 32, where entry v has to_status=1, sets status bit `vec` of entry v at the next clock edge.
- R7: A received packet with vector v < 32, where entry v has to_status=0, produces `soc_irq_valid` high for exactly one cycle, with `soc_irq_vec` equal to the entry's `vec`.
- R8: A received packet with vector 32 or above is dropped, with no status change and no pulse. The error count (bits 7:0 at address 5) increments by one and saturates at 255.
- R9: Writing to address 0 clears the status bits written as 1. Writing to address 1 sets the status bits written as 1. An event that sets a bit wins over a clear of that bit in the same cycle.
- R10: `irq_out` is 1 exactly when the status register is nonzero.
- R11: Writing a number n (in bits 5:0) to address 2 raises event n as if its line had risen.
- R12: The control table is loaded by writing the entry number to address 3 and then the entry to address 4: bit 0 enable, bit 1 local, bit 2 to_status, bits 12:8 vec. Reading address 4 returns the entry selected by address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 64 | Event lines, rising-edge sensitive |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| tx_valid | output | 1 | Outgoing packet available |
| tx_vec | output | 5 | Vector carried by the outgoing packet |
| tx_ready | input | 1 | Transmit path accepts the packet |
| rx_valid | input | 1 | Received packet strobe |
| rx_vec | input | 6 | Vector of the received packet |
| soc_irq_valid | output | 1 | One-cycle pulse toward the interrupt controller |
| soc_irq_vec | output | 5 | Vector of that pulse |
| irq_out | output | 1 | Combined local interrupt (status nonzero) |

## Verification
Every one of the 64 event lines is driven once as a local event and once as a remote event. Each uses a different vector, so a wrong table index or a wrong status bit shows up as a mismatch in both bit position and vector. All 64 receive vectors are swept, with the to_status flag alternating per entry. This separates the status path, the controller-pulse path and the drop path, and a long run of bad vectors pushes the error count into saturation. Simultaneous remote events, a full queue with a repeated event, and a status clear that collides with a status set are each driven on purpose to test ordering, loss detection and priority.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int VEC_W   = 5;
  localparam int STAT_W  = 1 << VEC_W;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 3;

  // control value register layout
  localparam int VAL_EN_B   = 0;
  localparam int VAL_LOC_B  = 1;
  localparam int VAL_TOS_B  = 2;
  localparam int VAL_VEC_LSB = 8;
  localparam int ERR_OVF_B  = 16;

  typedef struct packed {
    logic             en;
    logic             loc;
    logic             to_stat;
    logic [VEC_W-1:0] vec;
  } ctl_ent_t;

  typedef enum logic [ADDR_W-1:0] {
    RA_STAT = 3'd0,
    RA_SET  = 3'd1,
    RA_SWT  = 3'd2,
    RA_IDX  = 3'd3,
    RA_VAL  = 3'd4,
    RA_ERR  = 3'd5
  } reg_addr_e;

  function automatic ctl_ent_t val_to_ent(input logic [REG_W-1:0] d);
    ctl_ent_t e;
    e.en      = d[VAL_EN_B];
    e.loc     = d[VAL_LOC_B];
    e.to_stat = d[VAL_TOS_B];
    e.vec     = d[VAL_VEC_LSB +: VEC_W];
    return e;
  endfunction

  function automatic logic [REG_W-1:0] ent_to_val(input ctl_ent_t e);
    logic [REG_W-1:0] d;
    d = '0;
    d[VAL_EN_B]  = e.en;
    d[VAL_LOC_B] = e.loc;
    d[VAL_TOS_B] = e.to_stat;
    d[VAL_VEC_LSB +: VEC_W] = e.vec;
    return d;
  endfunction
endpackage

// File: rtl/lirq_ctl_table.sv
module lirq_ctl_table
  import lirq_pkg::*;
#(
  parameter int NUM_EVT = 64,
  parameter int IDX_W   = $clog2(NUM_EVT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  ctl_ent_t               wr_ent,
  output ctl_ent_t [NUM_EVT-1:0] tbl_o
);
  for (genvar g = 0; g < NUM_EVT; g++) begin : g_ent
    ctl_ent_t ent_q, ent_d;

    always_comb begin
      ent_d = ent_q;
      if (wr_en && (wr_idx == IDX_W'(g))) ent_d = wr_ent;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q <= '0;
      else        ent_q <= ent_d;
    end

    assign tbl_o[g] = ent_q;
  end
endmodule

// File: rtl/lirq_evt_detect.sv
module lirq_evt_detect
  import lirq_pkg::*;
#(
  parameter int NUM_EVT = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_EVT-1:0]     evt_i,
  input  logic [NUM_EVT-1:0]     sw_fire_i,
  input  ctl_ent_t [NUM_EVT-1:0] tbl_i,
  output logic [NUM_EVT-1:0]     fire_loc_o,
  output logic [NUM_EVT-1:0]     fire_rem_o
);
  logic [NUM_EVT-1:0] prev_q, prev_d;
  logic [NUM_EVT-1:0] unused_bits;

  always_comb prev_d = evt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  always_comb begin
    for (int i = 0; i < NUM_EVT; i++) begin
      logic hit;
      hit           = ((evt_i[i] & ~prev_q[i]) | sw_fire_i[i]) & tbl_i[i].en;
      fire_loc_o[i] = hit &  tbl_i[i].loc;
      fire_rem_o[i] = hit & ~tbl_i[i].loc;
      unused_bits[i] = ^{tbl_i[i].to_stat, tbl_i[i].vec};
    end
  end
endmodule

// File: rtl/lirq_tx_queue.sv
module lirq_tx_queue
  import lirq_pkg::*;
#(
  parameter int NUM_EVT = 64,
  parameter int IDX_W   = $clog2(NUM_EVT),
  parameter int DEPTH   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_EVT-1:0]     fire_rem_i,
  input  ctl_ent_t [NUM_EVT-1:0] tbl_i,
  input  logic                   tx_ready_i,
  output logic                   tx_valid_o,
  output logic [VEC_W-1:0]       tx_vec_o,
  output logic                   lost_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [NUM_EVT-1:0] pend_q, pend_d, gnt_oh;
  logic [PTR_W:0]     wr_q, wr_d, rd_q, rd_d;
  logic [VEC_W-1:0]   mem_q [DEPTH];
  logic [VEC_W-1:0]   push_vec;
  logic [IDX_W-1:0]   gnt_idx;
  logic               gnt_ok, full, empty, push, pop;
  logic [NUM_EVT-1:0] unused_bits;

  // lowest pending event line wins the queue slot
  always_comb begin
    gnt_ok  = 1'b0;
    gnt_idx = '0;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        gnt_ok  = 1'b1;
        gnt_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    empty    = (wr_q == rd_q);
    full     = (wr_q[PTR_W] != rd_q[PTR_W]) && (wr_q[PTR_W-1:0] == rd_q[PTR_W-1:0]);
    push     = gnt_ok && !full;
    pop      = !empty && tx_ready_i;
    gnt_oh   = push ? ({{(NUM_EVT-1){1'b0}}, 1'b1} << gnt_idx) : '0;
    push_vec = tbl_i[gnt_idx].vec;
    pend_d   = (pend_q & ~gnt_oh) | fire_rem_i;
    lost_o   = |(fire_rem_i & pend_q & ~gnt_oh);
    wr_d     = push ? wr_q + 1'b1 : wr_q;
    rd_d     = pop  ? rd_q + 1'b1 : rd_q;
    for (int i = 0; i < NUM_EVT; i++)
      unused_bits[i] = ^{tbl_i[i].en, tbl_i[i].loc, tbl_i[i].to_stat};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      wr_q   <= '0;
      rd_q   <= '0;
    end else begin
      pend_q <= pend_d;
      wr_q   <= wr_d;
      rd_q   <= rd_d;
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic [VEC_W-1:0] slot_d;
    always_comb begin
      slot_d = mem_q[s];
      if (push && (wr_q[PTR_W-1:0] == PTR_W'(s))) slot_d = push_vec;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[s] <= '0;
      else        mem_q[s] <= slot_d;
    end
  end

  assign tx_valid_o = !empty;
  assign tx_vec_o   = mem_q[rd_q[PTR_W-1:0]];
endmodule

// File: rtl/lirq_rx_map.sv
module lirq_rx_map
  import lirq_pkg::*;
#(
  parameter int NUM_EVT = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_valid_i,
  input  logic [VEC_W:0]         rx_vec_i,
  input  ctl_ent_t [NUM_EVT-1:0] tbl_i,
  output logic [STAT_W-1:0]      stat_set_o,
  output logic                   bad_o,
  output logic                   soc_valid_o,
  output logic [VEC_W-1:0]       soc_vec_o
);
  ctl_ent_t         ent;
  logic             in_rng, soc_v_d;
  logic [VEC_W-1:0] soc_vec_d;
  logic [NUM_EVT-1:0] unused_bits;

  always_comb begin
    in_rng     = rx_valid_i && !rx_vec_i[VEC_W];
    bad_o      = rx_valid_i &&  rx_vec_i[VEC_W];
    ent        = tbl_i[rx_vec_i[VEC_W-1:0]];
    stat_set_o = '0;
    if (in_rng && ent.to_stat) stat_set_o[ent.vec] = 1'b1;
    soc_v_d    = in_rng && !ent.to_stat;
    soc_vec_d  = soc_v_d ? ent.vec : soc_vec_o;
    for (int i = 0; i < NUM_EVT; i++)
      unused_bits[i] = ^{tbl_i[i].en, tbl_i[i].loc};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soc_valid_o <= 1'b0;
      soc_vec_o   <= '0;
    end else begin
      soc_valid_o <= soc_v_d;
      soc_vec_o   <= soc_vec_d;
    end
  end
endmodule

// File: rtl/link_irq_router.sv
module link_irq_router
  import lirq_pkg::*;
#(
  parameter int NUM_EVT    = 64,
  parameter int FIFO_DEPTH = 4,
  parameter int ERR_W      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [REG_W-1:0]   cfg_wdata,
  output logic [REG_W-1:0]   cfg_rdata,
  output logic               tx_valid,
  output logic [VEC_W-1:0]   tx_vec,
  input  logic               tx_ready,
  input  logic               rx_valid,
  input  logic [VEC_W:0]     rx_vec,
  output logic               soc_irq_valid,
  output logic [VEC_W-1:0]   soc_irq_vec,
  output logic               irq_out
);
  localparam int IDX_W = $clog2(NUM_EVT);

  logic [1:0]            rst_sync_q;
  logic                  rst_s;
  ctl_ent_t [NUM_EVT-1:0] tbl;
  logic [NUM_EVT-1:0]    sw_fire, fire_loc, fire_rem;
  logic [STAT_W-1:0]     stat_q, stat_d, loc_set, rx_set;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [ERR_W-1:0]      err_q, err_d;
  logic                  ovf_q, ovf_d, lost, bad;
  logic                  wr_stat, wr_set, wr_swt, wr_idx, wr_val, wr_err;
  logic                  unused_wdata;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  always_comb begin
    wr_stat = cfg_we && (cfg_addr == RA_STAT);
    wr_set  = cfg_we && (cfg_addr == RA_SET);
    wr_swt  = cfg_we && (cfg_addr == RA_SWT);
    wr_idx  = cfg_we && (cfg_addr == RA_IDX);
    wr_val  = cfg_we && (cfg_addr == RA_VAL);
    wr_err  = cfg_we && (cfg_addr == RA_ERR);
    sw_fire = '0;
    if (wr_swt && (32'(cfg_wdata[IDX_W-1:0]) < NUM_EVT)) sw_fire[cfg_wdata[IDX_W-1:0]] = 1'b1;
    unused_wdata = ^cfg_wdata;
  end

  lirq_ctl_table #(.NUM_EVT(NUM_EVT), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_val), .wr_idx(idx_q),
    .wr_ent(val_to_ent(cfg_wdata)), .tbl_o(tbl)
  );

  lirq_evt_detect #(.NUM_EVT(NUM_EVT)) u_detect (
    .clk(clk), .rst_n(rst_s), .evt_i(evt_in), .sw_fire_i(sw_fire),
    .tbl_i(tbl), .fire_loc_o(fire_loc), .fire_rem_o(fire_rem)
  );

  lirq_tx_queue #(.NUM_EVT(NUM_EVT), .IDX_W(IDX_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_s), .fire_rem_i(fire_rem), .tbl_i(tbl),
    .tx_ready_i(tx_ready), .tx_valid_o(tx_valid), .tx_vec_o(tx_vec), .lost_o(lost)
  );

  lirq_rx_map #(.NUM_EVT(NUM_EVT)) u_rxmap (
    .clk(clk), .rst_n(rst_s), .rx_valid_i(rx_valid), .rx_vec_i(rx_vec),
    .tbl_i(tbl), .stat_set_o(rx_set), .bad_o(bad),
    .soc_valid_o(soc_irq_valid), .soc_vec_o(soc_irq_vec)
  );

  // next-state for the register file
  always_comb begin
    loc_set = '0;
    for (int i = 0; i < NUM_EVT; i++)
      if (fire_loc[i]) loc_set[tbl[i].vec] = 1'b1;

    stat_d = stat_q;
    if (wr_stat) stat_d = stat_d & ~cfg_wdata[STAT_W-1:0];
    stat_d = stat_d | loc_set | rx_set;
    if (wr_set)  stat_d = stat_d | cfg_wdata[STAT_W-1:0];

    idx_d = wr_idx ? cfg_wdata[IDX_W-1:0] : idx_q;

    err_d = err_q;
    if (bad && (err_q != {ERR_W{1'b1}})) err_d = err_q + 1'b1;

    ovf_d = ovf_q;
    if (wr_err && cfg_wdata[ERR_OVF_B]) ovf_d = 1'b0;
    if (lost) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      stat_q <= '0;
      idx_q  <= '0;
      err_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      idx_q  <= idx_d;
      err_q  <= err_d;
      ovf_q  <= ovf_d;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (reg_addr_e'(cfg_addr))
      RA_STAT: cfg_rdata[STAT_W-1:0] = stat_q;
      RA_IDX:  cfg_rdata[IDX_W-1:0]  = idx_q;
      RA_VAL:  cfg_rdata = ent_to_val(tbl[idx_q]);
      RA_ERR: begin
        cfg_rdata[ERR_W-1:0]  = err_q;
        cfg_rdata[ERR_OVF_B]  = ovf_q;
      end
      default: cfg_rdata = '0;
    endcase
  end

  assign irq_out = |stat_q;
endmodule

// File: rtl/lirq_checker.sv
module lirq_checker #(
  parameter int ERR_W = 8,
  parameter int NUM_EVT = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_EVT-1:0] evt_in,
  input logic               cfg_we,
  input logic               tx_valid,
  input logic               tx_ready,
  input logic [4:0]         tx_vec,
  input logic               rx_valid,
  input logic [5:0]         rx_vec,
  input logic               soc_irq_valid,
  input logic               irq_out,
  input logic [ERR_W-1:0]   err_cnt
);
  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_vec));

  assert_soc_from_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soc_irq_valid |-> $past(rx_valid) && !$past(rx_vec[5]));

  assert_bad_no_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_vec[5] |=> !soc_irq_valid);

  assert_err_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_vec[5] && (err_cnt != {ERR_W{1'b1}}) |=> err_cnt == $past(err_cnt) + 1'b1);

  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(rx_valid) || $past(cfg_we) || ($past(evt_in) != '0));
endmodule

bind link_irq_router lirq_checker #(.ERR_W(ERR_W), .NUM_EVT(NUM_EVT)) u_chk (
  .clk(clk), .rst_n(rst_s), .evt_in(evt_in), .cfg_we(cfg_we),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_vec(tx_vec),
  .rx_valid(rx_valid), .rx_vec(rx_vec), .soc_irq_valid(soc_irq_valid),
  .irq_out(irq_out), .err_cnt(err_q)
);

// File: tb/link_irq_router_bench.sv
module link_irq_router_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] evt_in;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        tx_valid, tx_ready;
  logic [4:0]  tx_vec;
  logic        rx_valid;
  logic [5:0]  rx_vec;
  logic        soc_irq_valid;
  logic [4:0]  soc_irq_vec;
  logic        irq_out;

  int vectors = 0;
  int fails   = 0;

  always #5 clk = ~clk;

  link_irq_router u_link_irq_router (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .tx_valid(tx_valid), .tx_vec(tx_vec), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_vec(rx_vec), .soc_irq_valid(soc_irq_valid),
    .soc_irq_vec(soc_irq_vec), .irq_out(irq_out)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic set_ent(input int i, input bit en, input bit loc, input bit tos, input int vec);
    wr(3'd3, 32'(i));
    wr(3'd4, (32'(vec) << 8) | (32'(tos) << 2) | (32'(loc) << 1) | 32'(en));
  endtask

  task automatic pop_expect(input int exp, input string tag);
    check(tx_valid === 1'b1 && tx_vec === 5'(exp), tag, {26'b0, tx_valid, tx_vec}, 32'h20 | 32'(exp));
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int exp_err;
    rst_n = 1'b0; evt_in = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    tx_ready = 1'b0; rx_valid = 1'b0; rx_vec = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(3'd0, d); check(d == 0, "R1 status", d, 0);
    rd(3'd5, d); check(d == 0, "R1 err/ovf", d, 0);
    rd(3'd4, d); check(d == 0, "R1 entry0", d, 0);
    check(irq_out == 0 && tx_valid == 0 && soc_irq_valid == 0, "R1 outputs",
          {29'b0, irq_out, tx_valid, soc_irq_valid}, 0);

    // R12 table load and readback
    for (int i = 0; i < 64; i++) set_ent(i, i[0], i[1], i[2], (i * 3) % 32);
    for (int i = 0; i < 64; i++) begin
      logic [31:0] e;
      e = (32'((i * 3) % 32) << 8) | (32'(i[2]) << 2) | (32'(i[1]) << 1) | 32'(i[0]);
      wr(3'd3, 32'(i));
      rd(3'd4, d); check(d == e, "R12 readback", d, e);
    end

    // R2 / R10 local events on every line
    for (int i = 0; i < 64; i++) begin
      int v;
      v = (i * 7) % 32;
      set_ent(i, 1, 1, 0, v);
      evt_in[i] = 1'b1;
      @(negedge clk);
      rd(3'd0, d); check(d == (32'd1 << v), "R2 local set", d, 32'd1 << v);
      check(irq_out == 1'b1, "R10 irq high", 32'(irq_out), 1);
      wr(3'd0, 32'hFFFF_FFFF);
      @(negedge clk);
      rd(3'd0, d); check(d == 0, "R2 level no retrigger", d, 0);
      check(irq_out == 1'b0, "R10 irq low", 32'(irq_out), 0);
      evt_in[i] = 1'b0;
      @(negedge clk);
    end

    // R3 disabled events
    for (int i = 0; i < 64; i += 9) begin
      set_ent(i, 0, i[0], 0, 3);
      evt_in[i] = 1'b1;
      repeat (3) @(negedge clk);
      rd(3'd0, d); check(d == 0, "R3 disabled status", d, 0);
      check(tx_valid == 1'b0, "R3 disabled packet", 32'(tx_valid), 0);
      evt_in[i] = 1'b0;
      @(negedge clk);
    end

    // R4 remote events on every line
    for (int i = 0; i < 64; i++) begin
      int v;
      v = (i * 11) % 32;
      set_ent(i, 1, 0, 0, v);
      evt_in[i] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      evt_in[i] = 1'b0;
      pop_expect(v, "R4 remote packet");
      check(tx_valid == 1'b0, "R4 queue empty", 32'(tx_valid), 0);
      rd(3'd0, d); check(d == 0, "R4 no status", d, 0);
    end

    // R4 ordering of simultaneous events
    set_ent(3, 1, 0, 0, 3); set_ent(10, 1, 0, 0, 10); set_ent(40, 1, 0, 0, 8);
    @(negedge clk);
    evt_in[3] = 1; evt_in[10] = 1; evt_in[40] = 1;
    @(negedge clk);
    evt_in = '0;
    repeat (5) @(negedge clk);
    pop_expect(3, "R4 order first");
    pop_expect(10, "R4 order second");
    pop_expect(8, "R4 order third");

    // R5 queue full, repeated event, overflow flag
    for (int i = 0; i < 6; i++) set_ent(i, 1, 0, 0, i);
    rd(3'd5, d); check(d[16] == 1'b0, "R5 no ovf yet", d, 0);
    @(negedge clk);
    evt_in[5:0] = 6'h3F;
    @(negedge clk);
    evt_in = '0;
    repeat (6) @(negedge clk);
    check(tx_vec == 5'd0, "R5 held head", 32'(tx_vec), 0);
    evt_in[4] = 1'b1;
    @(negedge clk);
    evt_in[4] = 1'b0;
    rd(3'd5, d); check(d[16] == 1'b1, "R5 ovf set", d, 32'h10000);
    wr(3'd5, 32'h0001_0000);
    rd(3'd5, d); check(d[16] == 1'b0, "R5 ovf cleared", d, 0);
    for (int i = 0; i < 6; i++) pop_expect(i, "R5 drain order");
    @(negedge clk);
    check(tx_valid == 1'b0, "R5 drained", 32'(tx_valid), 0);

    // R6 / R7 / R8 receive sweep
    exp_err = 0;
    for (int v = 0; v < 64; v++) begin
      int m;
      m = (v + 5) % 32;
      if (v < 32) set_ent(v, 1, 1, v[0], m);
      @(negedge clk);
      rx_valid = 1'b1; rx_vec = 6'(v);
      @(negedge clk);
      rx_valid = 1'b0;
      rd(3'd0, d);
      if (v >= 32) begin
        exp_err++;
        check(d == 0 && soc_irq_valid == 0, "R8 dropped", d, 0);
        rd(3'd5, d); check(d[7:0] == 8'(exp_err), "R8 err count", d, 32'(exp_err));
      end else if (v[0]) begin
        check(d == (32'd1 << m) && soc_irq_valid == 0, "R6 rx to status", d, 32'd1 << m);
      end else begin
        check(d == 0 && soc_irq_valid == 1 && soc_irq_vec == 5'(m), "R7 rx pulse",
              {d[25:0], soc_irq_valid, soc_irq_vec}, {26'b0, 1'b1, 5'(m)});
      end
      @(negedge clk);
      check(soc_irq_valid == 0, "R7 pulse one cycle", 32'(soc_irq_valid), 0);
      wr(3'd0, 32'hFFFF_FFFF);
    end
    for (int k = 0; k < 230; k++) begin
      rx_valid = 1'b1; rx_vec = 6'(32 + (k % 32));
      @(negedge clk);
    end
    rx_valid = 1'b0;
    @(negedge clk);
    rd(3'd5, d); check(d[7:0] == 8'd255, "R8 saturate", d, 255);

    // R9 set / clear / priority
    wr(3'd1, 32'hA5A5_0F0F);
    rd(3'd0, d); check(d == 32'hA5A5_0F0F, "R9 set reg", d, 32'hA5A5_0F0F);
    wr(3'd0, 32'h0000_0F00);
    rd(3'd0, d); check(d == 32'hA5A5_000F, "R9 w1c", d, 32'hA5A5_000F);
    wr(3'd0, 32'hFFFF_FFFF);
    set_ent(7, 1, 1, 0, 9);
    wr(3'd1, 32'h200);
    @(negedge clk);
    evt_in[7] = 1'b1; cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 32'h200;
    @(negedge clk);
    cfg_we = 1'b0; evt_in[7] = 1'b0;
    rd(3'd0, d); check(d == 32'h200, "R9 set beats clear", d, 32'h200);
    wr(3'd0, 32'hFFFF_FFFF);

    // R11 software trigger
    set_ent(20, 1, 1, 0, 17);
    wr(3'd2, 32'd20);
    rd(3'd0, d); check(d == (32'd1 << 17), "R11 sw local", d, 32'd1 << 17);
    wr(3'd0, 32'hFFFF_FFFF);
    set_ent(21, 1, 0, 0, 4);
    wr(3'd2, 32'd21);
    @(negedge clk);
    pop_expect(4, "R11 sw remote");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule